// File: doc/BRIEF.md
# Crossbar master-port front end: region decode and wait-state control

This block sits at the entry of one master port of an AHB-Lite crossbar. It watches the address phase that a bus master presents and compares the full address against a programmable base and mask pair for every slave port. From that comparison it raises a one-hot request toward the per-slave arbiters. When the chosen slave port is granted in the same cycle, the address phase goes straight through to the slave side. When the grant is not there yet, the block captures the address phase and holds it. It also stalls the master with wait states until the grant arrives.

In the data phase the block returns the ready, response and read data of the slave that accepted the address phase. A register that moves only at transfer boundaries selects that slave. When no slave is involved, the block answers locally. An idle bus gets a zero-wait OKAY. An address that falls in no region gets a two-cycle ERROR response. The arbitration policy is not part of this block; it only consumes grant bits.

Top module: `xbar_mport_front`

## Requirements
- R1: Slave k is addressed when (m_addr AND mask_k) equals (base_k AND mask_k). Example: base 32'h1000_0000 with mask 32'hF000_0000 covers 32'h1000_0000 to 32'h1FFF_FFFF. Example: base 32'h4000_0000 with mask 32'hE000_0000 covers 32'h4000_0000 to 32'h5FFF_FFFF. In an accepted address phase, slv_req has bit k set and no other bit.
- R2: When several regions match one address, only the lowest-numbered slave is requested. slv_req never has more than one bit set.
- R3: A cycle with m_sel=0, or with m_trans equal to 2'b00 (idle) or 2'b01 (busy), raises no request. The data phase that follows such a cycle returns m_readyout=1 and m_resp=0 (OKAY) in the next cycle.
- R4: A transfer is an address phase with m_ready=1, m_sel=1 and m_trans equal to 2'b10 or 2'b11. If the transfer is granted in its own cycle, the full-width m_addr and the control appear unchanged on the fwd_* outputs in that cycle. From the next cycle, m_readyout, m_resp and m_rdata follow slv_ready, slv_resp and slv_rdata of that slave, with m_resp=1 meaning ERROR.
- R5: If the target slave is not granted, the address phase is captured. From the next cycle, m_readyout stays 0 until the cycle after the grant. During that time slv_req and the fwd_* outputs keep the captured values, whatever the live inputs do.
- R6: A transfer whose address matches no region raises no request. It is answered with m_readyout=0 and m_resp=1 in the first cycle after it, then m_readyout=1 and m_resp=1 in the second cycle.
- R7: While m_ready is 0 and no captured phase is pending, live address inputs raise no request. The data-phase selection does not change in such a cycle: m_rdata and m_readyout keep following the slave that owns the data phase.
- R8: During and right after reset, m_readyout is 1, m_resp is 0, m_rdata is 0 and slv_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_sel | input | 1 | Port select from the master bus |
| m_trans | input | 2 | Transfer type (00 idle, 01 busy, 10 nonseq, 11 seq) |
| m_addr | input | ADDR_W | Master address |
| m_write | input | 1 | Write when 1 |
| m_size | input | 3 | Transfer size |
| m_burst | input | 3 | Burst type |
| m_prot | input | 4 | Protection attributes |
| m_lock | input | 1 | Locked sequence marker |
| m_ready | input | 1 | Ready of the master bus (end of the previous data phase) |
| m_readyout | output | 1 | Ready driven back to the master bus |
| m_resp | output | 1 | Response to the master, 0 OKAY, 1 ERROR |
| m_rdata | output | DATA_W | Read data to the master |
| region_base | input | SLAVES*ADDR_W | Base address per slave, slave k at bits [k*ADDR_W +: ADDR_W] |
| region_mask | input | SLAVES*ADDR_W | Mask per slave, same packing |
| slv_req | output | SLAVES | One-hot request / select toward the slave ports |
| slv_grant | input | SLAVES | Grant from each slave port's arbiter |
| fwd_addr | output | ADDR_W | Address phase address toward the slaves |
| fwd_trans | output | 2 | Forwarded transfer type |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_size | output | 3 | Forwarded size |
| fwd_burst | output | 3 | Forwarded burst type |
| fwd_prot | output | 4 | Forwarded protection |
| fwd_lock | output | 1 | Forwarded lock |
| slv_ready | input | SLAVES | Ready of each slave |
| slv_resp | input | SLAVES | Response of each slave |
| slv_rdata | input | SLAVES*DATA_W | Read data of each slave, packed like region_base |

## Verification
The request, the fwd_* outputs and the stall ready are combinational in the address-phase cycle, so the bench checks them one time step after driving inputs on the falling edge. The data-phase ready, response and read data come out of one register. They are due on the falling edge after the clock edge that accepted the address phase, or after the edge that saw the grant for a captured phase. The two error cycles are due on the first and second falling edges after an unmapped transfer. The bench ties m_ready to m_readyout, so every stall it counts is the one the block itself produces. It samples each result at exactly those falling edges.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

   // data-phase owner of the master port
   typedef enum logic [2:0] {
      DP_IDLE = 3'd0,   // local zero-wait OKAY
      DP_WAIT = 3'd1,   // captured phase waiting for grant
      DP_SLV  = 3'd2,   // a slave owns the data phase
      DP_ERR1 = 3'd3,   // first cycle of local ERROR
      DP_ERR2 = 3'd4    // second cycle of local ERROR
   } dphase_e;

   // address-phase control carried next to the address
   typedef struct packed {
      logic [1:0] trans;
      logic       write;
      logic [2:0] size;
      logic [2:0] burst;
      logic [3:0] prot;
      logic       lock;
   } actl_t;

endpackage

// File: rtl/mpf_region_dec.sv
module mpf_region_dec #(
   parameter int ADDR_W = 32,
   parameter int SLAVES = 4,
   parameter int IDX_W  = 2
) (
   input  logic [ADDR_W-1:0]        addr,
   input  logic [SLAVES*ADDR_W-1:0] base,
   input  logic [SLAVES*ADDR_W-1:0] mask,
   output logic                     hit,
   output logic [IDX_W-1:0]         idx,
   output logic [SLAVES-1:0]        onehot
);

   logic [SLAVES-1:0] raw;

   // per-region compare: bits under the mask must agree
   for (genvar k = 0; k < SLAVES; k++) begin : g_cmp
      assign raw[k] = ~|((addr ^ base[k*ADDR_W +: ADDR_W]) & mask[k*ADDR_W +: ADDR_W]);
   end

   assign hit = |raw;

   if (SLAVES == 1) begin : g_single
      assign idx    = '0;
      assign onehot = raw;
   end else begin : g_multi
      // lowest index wins on overlapping regions
      always_comb begin
         idx = '0;
         for (int k = SLAVES - 1; k >= 0; k--) begin
            if (raw[k]) idx = IDX_W'(k);
         end
      end
      always_comb begin
         onehot = '0;
         if (hit) onehot[idx] = 1'b1;
      end
   end

endmodule

// File: rtl/mpf_hold.sv
module mpf_hold
   import mpf_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SLAVES = 4,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              clear,
   input  logic [ADDR_W-1:0] addr_d,
   input  actl_t             ctl_d,
   input  logic [IDX_W-1:0]  idx_d,
   input  logic [SLAVES-1:0] oh_d,
   output logic              vld,
   output logic [ADDR_W-1:0] addr_q,
   output actl_t             ctl_q,
   output logic [IDX_W-1:0]  idx_q,
   output logic [SLAVES-1:0] oh_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld    <= 1'b0;
         addr_q <= '0;
         ctl_q  <= '0;
         idx_q  <= '0;
         oh_q   <= '0;
      end else if (load) begin
         vld    <= 1'b1;
         addr_q <= addr_d;
         ctl_q  <= ctl_d;
         idx_q  <= idx_d;
         oh_q   <= oh_d;
      end else if (clear) begin
         vld    <= 1'b0;
      end
   end

endmodule

// File: rtl/mpf_dphase.sv
module mpf_dphase
   import mpf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SLAVES = 4,
   parameter int IDX_W  = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ld,
   input  dphase_e                  nxt,
   input  logic [IDX_W-1:0]         nxt_idx,
   input  logic [SLAVES-1:0]        slv_ready,
   input  logic [SLAVES-1:0]        slv_resp,
   input  logic [SLAVES*DATA_W-1:0] slv_rdata,
   output dphase_e                  state,
   output logic                     readyout,
   output logic                     resp,
   output logic [DATA_W-1:0]        rdata
);

   logic [IDX_W-1:0] own;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= DP_IDLE;
         own   <= '0;
      end else if (state == DP_ERR1) begin
         state <= DP_ERR2;
      end else if (ld) begin
         state <= nxt;
         own   <= nxt_idx;
      end
   end

   always_comb begin
      readyout = 1'b1;
      resp     = 1'b0;
      rdata    = '0;
      unique case (state)
         DP_IDLE: ;
         DP_WAIT: readyout = 1'b0;
         DP_SLV: begin
            readyout = slv_ready[own];
            resp     = slv_resp[own];
            rdata    = slv_rdata[own*DATA_W +: DATA_W];
         end
         DP_ERR1: begin
            readyout = 1'b0;
            resp     = 1'b1;
         end
         DP_ERR2: resp = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/xbar_mport_front.sv
module xbar_mport_front
   import mpf_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int SLAVES = 4,
   localparam int IDX_W = (SLAVES > 1) ? $clog2(SLAVES) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     m_sel,
   input  logic [1:0]               m_trans,
   input  logic [ADDR_W-1:0]        m_addr,
   input  logic                     m_write,
   input  logic [2:0]               m_size,
   input  logic [2:0]               m_burst,
   input  logic [3:0]               m_prot,
   input  logic                     m_lock,
   input  logic                     m_ready,
   output logic                     m_readyout,
   output logic                     m_resp,
   output logic [DATA_W-1:0]        m_rdata,
   input  logic [SLAVES*ADDR_W-1:0] region_base,
   input  logic [SLAVES*ADDR_W-1:0] region_mask,
   output logic [SLAVES-1:0]        slv_req,
   input  logic [SLAVES-1:0]        slv_grant,
   output logic [ADDR_W-1:0]        fwd_addr,
   output logic [1:0]               fwd_trans,
   output logic                     fwd_write,
   output logic [2:0]               fwd_size,
   output logic [2:0]               fwd_burst,
   output logic [3:0]               fwd_prot,
   output logic                     fwd_lock,
   input  logic [SLAVES-1:0]        slv_ready,
   input  logic [SLAVES-1:0]        slv_resp,
   input  logic [SLAVES*DATA_W-1:0] slv_rdata
);

   // elaboration-time parameter checks
   if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_addr
      $error("xbar_mport_front: ADDR_W out of range");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("xbar_mport_front: DATA_W too small");
   end
   if (SLAVES < 1 || SLAVES > 64) begin : g_bad_slaves
      $error("xbar_mport_front: SLAVES out of range");
   end

   logic              live_hit;
   logic [IDX_W-1:0]  live_idx;
   logic [SLAVES-1:0] live_oh;
   actl_t             live_ctl;

   mpf_region_dec #(.ADDR_W(ADDR_W), .SLAVES(SLAVES), .IDX_W(IDX_W)) dec_i (
      .addr   (m_addr),
      .base   (region_base),
      .mask   (region_mask),
      .hit    (live_hit),
      .idx    (live_idx),
      .onehot (live_oh)
   );

   assign live_ctl = '{trans: m_trans, write: m_write, size: m_size,
                       burst: m_burst, prot: m_prot, lock: m_lock};

   logic              hold_vld;
   logic              hold_ld;
   logic              hold_clr;
   logic [ADDR_W-1:0] hold_addr;
   actl_t             hold_ctl;
   logic [IDX_W-1:0]  hold_idx;
   logic [SLAVES-1:0] hold_oh;

   mpf_hold #(.ADDR_W(ADDR_W), .SLAVES(SLAVES), .IDX_W(IDX_W)) hold_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (hold_ld),
      .clear  (hold_clr),
      .addr_d (m_addr),
      .ctl_d  (live_ctl),
      .idx_d  (live_idx),
      .oh_d   (live_oh),
      .vld    (hold_vld),
      .addr_q (hold_addr),
      .ctl_q  (hold_ctl),
      .idx_q  (hold_idx),
      .oh_q   (hold_oh)
   );

   dphase_e          dp_state;
   dphase_e          dp_nxt;
   logic             dp_ld;
   logic [IDX_W-1:0] dp_idx_nxt;

   logic xfer;
   logic live_go;
   logic gnt_live;
   logic gnt_hold;

   assign xfer     = m_sel & m_trans[1];
   assign live_go  = m_ready & xfer & ~hold_vld & (dp_state != DP_ERR1);
   assign gnt_live = |(live_oh & slv_grant);
   assign gnt_hold = |(hold_oh & slv_grant);

   always_comb begin
      hold_ld    = 1'b0;
      hold_clr   = 1'b0;
      dp_ld      = 1'b0;
      dp_nxt     = DP_IDLE;
      dp_idx_nxt = live_idx;
      if (hold_vld) begin
         if (gnt_hold) begin
            dp_ld      = 1'b1;
            dp_nxt     = DP_SLV;
            dp_idx_nxt = hold_idx;
            hold_clr   = 1'b1;
         end
      end else if (m_ready && dp_state != DP_ERR1) begin
         dp_ld = 1'b1;
         if (!xfer) begin
            dp_nxt = DP_IDLE;
         end else if (!live_hit) begin
            dp_nxt = DP_ERR1;
         end else if (gnt_live) begin
            dp_nxt = DP_SLV;
         end else begin
            dp_nxt  = DP_WAIT;
            hold_ld = 1'b1;
         end
      end
   end

   mpf_dphase #(.DATA_W(DATA_W), .SLAVES(SLAVES), .IDX_W(IDX_W)) dp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld        (dp_ld),
      .nxt       (dp_nxt),
      .nxt_idx   (dp_idx_nxt),
      .slv_ready (slv_ready),
      .slv_resp  (slv_resp),
      .slv_rdata (slv_rdata),
      .state     (dp_state),
      .readyout  (m_readyout),
      .resp      (m_resp),
      .rdata     (m_rdata)
   );

   actl_t fwd_ctl;

   assign slv_req  = hold_vld ? hold_oh : (live_go ? live_oh : '0);
   assign fwd_addr = hold_vld ? hold_addr : m_addr;
   assign fwd_ctl  = hold_vld ? hold_ctl : live_ctl;

   assign fwd_trans = fwd_ctl.trans;
   assign fwd_write = fwd_ctl.write;
   assign fwd_size  = fwd_ctl.size;
   assign fwd_burst = fwd_ctl.burst;
   assign fwd_prot  = fwd_ctl.prot;
   assign fwd_lock  = fwd_ctl.lock;

endmodule

// File: rtl/mpf_chk.sv
module mpf_chk
   import mpf_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SLAVES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              m_sel,
   input logic [1:0]        m_trans,
   input logic              m_ready,
   input logic              m_readyout,
   input logic              m_resp,
   input logic [SLAVES-1:0] slv_req,
   input logic [SLAVES-1:0] slv_grant,
   input logic [ADDR_W-1:0] fwd_addr,
   input logic              hold_vld,
   input dphase_e           dp_state
);

   // R2
   req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slv_req));

   // R5
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_vld && !(|(slv_req & slv_grant))) |=>
         (hold_vld && $stable(slv_req) && $stable(fwd_addr)));

   // R5
   hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_vld |-> !m_readyout);

   // R6
   err_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_state == DP_ERR1) |-> (!m_readyout && m_resp));

   // R6
   err_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_state == DP_ERR1) |=> (m_readyout && m_resp));

   // R3
   idle_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_vld && !(m_sel && m_trans[1])) |-> (slv_req == '0));

   // R7
   stall_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_vld && !m_ready) |-> (slv_req == '0));

endmodule

bind xbar_mport_front mpf_chk #(.ADDR_W(ADDR_W), .SLAVES(SLAVES)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .m_sel      (m_sel),
   .m_trans    (m_trans),
   .m_ready    (m_ready),
   .m_readyout (m_readyout),
   .m_resp     (m_resp),
   .slv_req    (slv_req),
   .slv_grant  (slv_grant),
   .fwd_addr   (fwd_addr),
   .hold_vld   (hold_vld),
   .dp_state   (dp_state)
);

// File: tb/xbar_mport_front_tb_top.sv
module xbar_mport_front_tb_top;

   localparam int CLK_P  = 10;
   localparam int AW     = 32;
   localparam int DW     = 32;
   localparam int NS     = 4;
   localparam int N_RAND = 150;

   localparam logic [AW-1:0] BASE [NS] = '{32'h1000_0000, 32'h4000_0000, 32'h8000_0000, 32'h5000_0000};
   localparam logic [AW-1:0] MASK [NS] = '{32'hF000_0000, 32'hE000_0000, 32'hC000_0000, 32'hF000_0000};

   logic clk = 1'b0;
   logic rst_n = 1'b0;

   logic           m_sel = 1'b0;
   logic [1:0]     m_trans = 2'b00;
   logic [AW-1:0]  m_addr = '0;
   logic           m_write = 1'b0;
   logic [2:0]     m_size = 3'd2;
   logic [2:0]     m_burst = 3'd0;
   logic [3:0]     m_prot = 4'h1;
   logic           m_lock = 1'b0;
   logic           m_ready;
   logic           m_readyout;
   logic           m_resp;
   logic [DW-1:0]  m_rdata;
   logic [NS*AW-1:0] region_base;
   logic [NS*AW-1:0] region_mask;
   logic [NS-1:0]  slv_req;
   logic [NS-1:0]  slv_grant = '0;
   logic [AW-1:0]  fwd_addr;
   logic [1:0]     fwd_trans;
   logic           fwd_write;
   logic [2:0]     fwd_size;
   logic [2:0]     fwd_burst;
   logic [3:0]     fwd_prot;
   logic           fwd_lock;
   logic [NS-1:0]  slv_ready = '1;
   logic [NS-1:0]  slv_resp = '0;
   logic [NS*DW-1:0] slv_rdata = '0;

   int chk_n  = 0;
   int fail_n = 0;

   always #(CLK_P/2) clk = ~clk;

   // single master on its bus: its ready is the port's own ready
   assign m_ready = m_readyout;

   for (genvar k = 0; k < NS; k++) begin : g_cfg
      assign region_base[k*AW +: AW] = BASE[k];
      assign region_mask[k*AW +: AW] = MASK[k];
   end

   xbar_mport_front #(.ADDR_W(AW), .DATA_W(DW), .SLAVES(NS)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .m_sel(m_sel), .m_trans(m_trans), .m_addr(m_addr), .m_write(m_write),
      .m_size(m_size), .m_burst(m_burst), .m_prot(m_prot), .m_lock(m_lock),
      .m_ready(m_ready), .m_readyout(m_readyout), .m_resp(m_resp), .m_rdata(m_rdata),
      .region_base(region_base), .region_mask(region_mask),
      .slv_req(slv_req), .slv_grant(slv_grant),
      .fwd_addr(fwd_addr), .fwd_trans(fwd_trans), .fwd_write(fwd_write),
      .fwd_size(fwd_size), .fwd_burst(fwd_burst), .fwd_prot(fwd_prot), .fwd_lock(fwd_lock),
      .slv_ready(slv_ready), .slv_resp(slv_resp), .slv_rdata(slv_rdata)
   );

   function automatic int exp_slave(input logic [AW-1:0] a);
      for (int k = 0; k < NS; k++) begin
         if ((a & MASK[k]) == (BASE[k] & MASK[k])) return k;
      end
      return -1;
   endfunction

   function automatic int hit_count(input logic [AW-1:0] a);
      int c = 0;
      for (int k = 0; k < NS; k++) begin
         if ((a & MASK[k]) == (BASE[k] & MASK[k])) c++;
      end
      return c;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] expv);
      chk_n++;
      if (!ok) begin
         fail_n++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic drive_idle();
      m_sel   = 1'($urandom_range(0, 1));
      m_trans = m_sel ? 2'($urandom_range(0, 1)) : 2'($urandom);
      m_addr  = $urandom;
   endtask

   task automatic do_xfer(input logic [AW-1:0] a, input int dly, input int wt);
      int             e;
      logic [NS-1:0]  oh;
      logic [DW-1:0]  pat;
      logic           w;
      logic           rsp;
      string          dec_tag;
      e   = exp_slave(a);
      oh  = (e >= 0) ? NS'(1 << e) : '0;
      pat = $urandom;
      w   = 1'($urandom_range(0, 1));
      rsp = 1'($urandom_range(0, 1));
      dec_tag = (hit_count(a) > 1) ? "R2" : "R1";
      @(negedge clk);
      m_sel   = 1'b1;
      m_trans = 2'b10 | 2'($urandom_range(0, 1));
      m_addr  = a;
      m_write = w;
      slv_grant = (dly == 0) ? (NS'($urandom) | oh) : (NS'($urandom) & ~oh);
      #1;
      check(slv_req == oh, dec_tag, "request vector", 64'(slv_req), 64'(oh));
      if (e < 0) begin
         @(negedge clk);
         drive_idle();
         #1;
         check(!m_readyout && m_resp, "R6", "first error cycle {rdy,resp}",
               64'({m_readyout, m_resp}), 64'(2'b01));
         @(negedge clk);
         #1;
         check(m_readyout && m_resp, "R6", "second error cycle {rdy,resp}",
               64'({m_readyout, m_resp}), 64'(2'b11));
      end else begin
         check(fwd_addr == a && fwd_write == w, "R4", "forwarded address",
               64'(fwd_addr), 64'(a));
         for (int d = 1; d <= dly; d++) begin
            @(negedge clk);
            m_addr  = $urandom;
            m_trans = 2'($urandom);
            m_write = ~w;
            slv_grant = (d == dly) ? oh : (NS'($urandom) & ~oh);
            #1;
            check(!m_readyout, "R5", "stall ready", 64'(m_readyout), 64'd0);
            check(slv_req == oh, "R5", "held request", 64'(slv_req), 64'(oh));
            check(fwd_addr == a && fwd_write == w, "R5", "held address",
                  64'(fwd_addr), 64'(a));
         end
         for (int s = 0; s <= wt; s++) begin
            @(negedge clk);
            if (s < wt) begin
               m_sel = 1'b1; m_trans = 2'b10; m_addr = $urandom; slv_grant = '1;
            end else begin
               drive_idle();
            end
            slv_ready = NS'($urandom);
            slv_ready[e] = (s == wt);
            slv_resp = NS'($urandom);
            slv_resp[e] = (s == wt) ? rsp : 1'b0;
            for (int k = 0; k < NS; k++) slv_rdata[k*DW +: DW] = $urandom;
            slv_rdata[e*DW +: DW] = pat;
            #1;
            check(m_readyout == (s == wt), (s < wt) ? "R7" : "R4", "data-phase ready",
                  64'(m_readyout), 64'(s == wt));
            check(m_resp == slv_resp[e], "R4", "data-phase response",
                  64'(m_resp), 64'(slv_resp[e]));
            check(m_rdata == pat, (s < wt) ? "R7" : "R4", "read data",
                  64'(m_rdata), 64'(pat));
            if (s < wt) check(slv_req == '0, "R7", "no request while stalled",
                              64'(slv_req), 64'd0);
         end
      end
      @(negedge clk);
      drive_idle();
      slv_grant = NS'($urandom);
      #1;
      check(slv_req == '0, "R3", "idle request", 64'(slv_req), 64'd0);
      check(m_readyout && !m_resp && m_rdata == '0, "R3", "idle data phase {rdy,resp}",
            64'({m_readyout, m_resp}), 64'(2'b10));
   endtask

   initial begin
      #(CLK_P * 150000);
      fail_n++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240917));
      repeat (3) @(negedge clk);
      #1;
      check(m_readyout && !m_resp && m_rdata == '0 && slv_req == '0, "R8",
            "reset outputs {rdy,resp,req}", 64'({m_readyout, m_resp, slv_req}),
            64'({1'b1, 1'b0, 4'h0}));
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(m_readyout && !m_resp && slv_req == '0, "R8", "after reset {rdy,resp,req}",
            64'({m_readyout, m_resp, slv_req}), 64'({1'b1, 1'b0, 4'h0}));

      // directed boundary cases
      do_xfer(32'h1000_0000, 0, 0);   // R1 lower edge of slave 0
      do_xfer(32'h1FFF_FFFF, 2, 1);   // R1 upper edge, R5 wait
      do_xfer(32'h2000_0000, 0, 0);   // R6 just above slave 0
      do_xfer(32'h4000_0000, 1, 0);   // R1 slave 1 lower edge
      do_xfer(32'h5FFF_FFFF, 0, 2);   // R2 overlap with slave 3
      do_xfer(32'h5000_0000, 3, 0);   // R2 overlap
      do_xfer(32'h6000_0000, 0, 0);   // R6 above slave 1
      do_xfer(32'hBFFF_FFFF, 0, 0);   // R1 slave 2 upper edge
      do_xfer(32'hC000_0000, 0, 0);   // R6

      for (int n = 0; n < N_RAND; n++) begin
         do_xfer($urandom, $urandom_range(0, 3), $urandom_range(0, 2));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
      $finish;
   end

endmodule